// File: doc/BRIEF.md
# DMA Completion Interrupt Controller

This block sits between a peripheral interrupt cause and a small set of DMA channels. When the cause flag is pending and the channel assigned to it has both its request bit and its enable bit set, the block starts that channel instead of interrupting the CPU. It then tracks the transfer through a simple done/counter-zero handshake from the data mover. When the transfer ends, it issues single-cycle clear strobes for the cause flag, the channel request bit and the channel enable bit. The surrounding register file applies these strobes, and the block also raises either a CPU interrupt or a sticky global DMA-done flag.

Two modes exist. In unlinked mode a single channel runs, and what happens to the cause, request and enable bits depends on whether the counter hit zero and on whether that channel's completion interrupt is enabled. In linked mode one cause occurrence runs a chain of channels. Each channel carries a 3-bit next-channel pointer and a last-in-chain bit. The cause flag is always consumed, so the CPU sees no interrupt for it. Only the final channel can set the done flag. The mode is captured when the invocation starts. While a transfer runs, the block accepts no new invocation and raises no interrupt.

Top module: `dma_cmpl_irq_ctrl`

## Requirements
- R1: After reset `busy_o`, `xfer_start_o`, `cause_clr_o`, `req_clr_o`, `en_clr_o` and `done_flag_o` are all 0.
- R2: When idle, if `cause_flag_i` is 1 and bits `cause_ch_i` of both `req_bits_i` and `en_bits_i` are 1, then on the next cycle `busy_o` is 1, `xfer_start_o` pulses, `xfer_ch_o` equals `cause_ch_i`, and `cpu_irq_o` stays 0.
- R3: `cpu_irq_o` is 1 only when idle, with `cause_flag_i` and `cause_ie_i` both 1 and the assigned channel not both requested and enabled. It is 0 while a transfer runs and in the settle cycle after one.
- R4: In unlinked mode, a completion with `cnt_zero_i`=1 and the channel's `done_ie_i`=1 pulses only that channel's bit of `req_clr_o` (one-hot by channel number). The cause flag and enable bit are kept, so the pending cause then shows up as a CPU interrupt.
- R5: In unlinked mode, a completion with `cnt_zero_i`=0 pulses only `cause_clr_o`. The request and enable bits are kept.
- R6: In unlinked mode, a completion with `cnt_zero_i`=1 and `done_ie_i`=0 pulses `cause_clr_o` and the channel's bit of `en_clr_o`. The request bit is kept.
- R7: An unlinked invocation never changes `done_flag_o`.
- R8: In linked mode, completion of a channel that is not the end of the chain starts the channel named by its pointer: `xfer_start_o` pulses and `xfer_ch_o` takes the pointer value. No cause clear is issued. The channel's `en_clr_o` bit pulses exactly when `cnt_zero_i`=1.
- R9: In linked mode, no bit of `req_clr_o` ever pulses. At the chain end `cause_clr_o` pulses, and the ending channel's enable bit is cleared when its counter is zero.
- R10: `done_flag_o` is set only when a linked chain ends on a channel whose last bit is 1, with `cnt_zero_i`=1 and that channel's `done_ie_i`=1. It then holds until `done_flag_clr_i` is 1 for a cycle.
- R11: In linked mode, a pointer value of 4 or more ends the chain like a last bit does, but never sets `done_flag_o`.
- R12: While busy, changes on `cause_ch_i`, `cause_ie_i` and `link_mode_i` start nothing, and `xfer_ch_o` holds until the running channel completes. The mode used is the one sampled at invocation.
- R13: `cause_clr_o` and `req_clr_o` are one-cycle pulses, and all clear strobes are 0 in the idle cycle after a settle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cause_flag_i | input | 1 | Pending interrupt cause flag |
| cause_ie_i | input | 1 | Interrupt enable for the cause |
| cause_ch_i | input | 2 | DMA channel assigned to the cause |
| req_bits_i | input | 4 | Per-channel DMA request bits |
| en_bits_i | input | 4 | Per-channel DMA enable bits |
| done_ie_i | input | 4 | Per-channel completion-interrupt enable |
| link_mode_i | input | 1 | 1 selects chained channels |
| next_ptr_i | input | 12 | Next-channel pointer, channel i at bits [3i+2:3i] |
| last_bits_i | input | 4 | Per-channel last-in-chain bit |
| xfer_done_i | input | 1 | Data mover finished the running channel |
| cnt_zero_i | input | 1 | Transfer counter is zero, valid with xfer_done_i |
| done_flag_clr_i | input | 1 | Write-one clear of the done flag |
| busy_o | output | 1 | A channel transfer is running |
| xfer_start_o | output | 1 | Pulse: channel on xfer_ch_o begins |
| xfer_ch_o | output | 2 | Channel being run |
| cause_clr_o | output | 1 | Pulse: clear the cause flag |
| req_clr_o | output | 4 | Pulse: clear a channel request bit |
| en_clr_o | output | 4 | Pulse: clear a channel enable bit |
| cpu_irq_o | output | 1 | Interrupt request to the CPU |
| done_flag_o | output | 1 | Global DMA-done flag |

## Verification
Unlinked runs sweep all four combinations of counter-zero and completion-interrupt enable. This separates the three strobe outcomes of R4 to R6 and shows whether the kept cause surfaces as a CPU interrupt afterwards. Linked runs use random pointer graphs with forced termination, so chains end on a last bit, on an out-of-range pointer, or after several hops. This separates the done-flag rule from plain chain ending. Some runs disturb the cause channel, the interrupt enable and the mode mid-transfer, which shows that invocation blocking and the latched mode hold. Directed cases cover a three-hop chain, an invalid pointer and an interrupt with the channel disabled.

// File: rtl/dci_pkg.sv
package dci_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_RUN    = 2'd1,
    ST_SETTLE = 2'd2
  } dci_state_e;

  typedef struct packed {
    logic cause_clr;
    logic req_clr;
    logic en_clr;
    logic set_done;
    logic finish;
  } dci_action_t;

  // Outcome of one channel completion.
  function automatic dci_action_t dci_completion(
    input logic linked,
    input logic zero,
    input logic ie,
    input logic chain_end,
    input logic last_flag
  );
    dci_action_t a;
    if (!linked) begin
      a.finish    = 1'b1;
      a.set_done  = 1'b0;
      a.cause_clr = !(zero && ie);
      a.req_clr   = zero && ie;
      a.en_clr    = zero && !ie;
    end else begin
      a.finish    = chain_end;
      a.cause_clr = chain_end;
      a.req_clr   = 1'b0;
      a.en_clr    = zero;
      a.set_done  = chain_end && last_flag && zero && ie;
    end
    return a;
  endfunction

  // Pointer beyond the channel count terminates a chain.
  function automatic logic dci_ptr_bad(input int unsigned ptr, input int unsigned nch);
    return ptr >= nch;
  endfunction

endpackage

// File: rtl/dci_launch.sv
module dci_launch #(
  parameter int NUM_CH = 4,
  parameter int CH_W   = 2
) (
  input  logic              idle,
  input  logic              cause_flag,
  input  logic              cause_ie,
  input  logic [CH_W-1:0]   cause_ch,
  input  logic [NUM_CH-1:0] req_bits,
  input  logic [NUM_CH-1:0] en_bits,
  output logic              invoke,
  output logic              irq
);
  logic ch_ready;

  assign ch_ready = req_bits[cause_ch] && en_bits[cause_ch];
  assign invoke   = idle && cause_flag && ch_ready;
  // DMA takes precedence: the interrupt is held back when the channel can run.
  assign irq      = idle && cause_flag && cause_ie && !ch_ready;
endmodule

// File: rtl/dci_chain.sv
module dci_chain #(
  parameter int NUM_CH = 4,
  parameter int CH_W   = 2,
  parameter int PTR_W  = 3
) (
  input  logic [CH_W-1:0]         cur_ch,
  input  logic [NUM_CH*PTR_W-1:0] next_ptr,
  input  logic [NUM_CH-1:0]       last_bits,
  output logic                    chain_end,
  output logic                    last_flag,
  output logic [CH_W-1:0]         next_ch
);
  logic [PTR_W-1:0] ptr_arr [NUM_CH];
  logic [PTR_W-1:0] cur_ptr;
  logic             ptr_bad;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_unpack
    assign ptr_arr[g] = next_ptr[g*PTR_W +: PTR_W];
  end

  assign cur_ptr   = ptr_arr[cur_ch];
  assign ptr_bad   = dci_pkg::dci_ptr_bad(int'(unsigned'(cur_ptr)), NUM_CH);
  assign last_flag = last_bits[cur_ch];
  assign chain_end = last_flag || ptr_bad;
  assign next_ch   = cur_ptr[CH_W-1:0];
endmodule

// File: rtl/dci_done_flag.sv
module dci_done_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end
endmodule

// File: rtl/dma_cmpl_irq_ctrl.sv
module dma_cmpl_irq_ctrl #(
  parameter int NUM_CH = 4,
  parameter int PTR_W  = 3,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cause_flag_i,
  input  logic                    cause_ie_i,
  input  logic [CH_W-1:0]         cause_ch_i,
  input  logic [NUM_CH-1:0]       req_bits_i,
  input  logic [NUM_CH-1:0]       en_bits_i,
  input  logic [NUM_CH-1:0]       done_ie_i,
  input  logic                    link_mode_i,
  input  logic [NUM_CH*PTR_W-1:0] next_ptr_i,
  input  logic [NUM_CH-1:0]       last_bits_i,
  input  logic                    xfer_done_i,
  input  logic                    cnt_zero_i,
  input  logic                    done_flag_clr_i,
  output logic                    busy_o,
  output logic                    xfer_start_o,
  output logic [CH_W-1:0]         xfer_ch_o,
  output logic                    cause_clr_o,
  output logic [NUM_CH-1:0]       req_clr_o,
  output logic [NUM_CH-1:0]       en_clr_o,
  output logic                    cpu_irq_o,
  output logic                    done_flag_o
);
  import dci_pkg::*;

  dci_state_e        state_q;
  logic [CH_W-1:0]   cur_ch_q;
  logic              linked_q;

  // Named internal events, observed by the checker.
  logic              idle_w;
  logic              invoke_w;
  logic              run_done_w;
  logic              done_set_w;
  logic              chain_end_w;
  logic              last_flag_w;
  logic [CH_W-1:0]   next_ch_w;
  logic [NUM_CH-1:0] ch_sel_w;
  dci_action_t       act_w;

  assign idle_w     = (state_q == ST_IDLE);
  assign run_done_w = (state_q == ST_RUN) && xfer_done_i;

  dci_launch #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_launch (
    .idle       (idle_w),
    .cause_flag (cause_flag_i),
    .cause_ie   (cause_ie_i),
    .cause_ch   (cause_ch_i),
    .req_bits   (req_bits_i),
    .en_bits    (en_bits_i),
    .invoke     (invoke_w),
    .irq        (cpu_irq_o)
  );

  dci_chain #(.NUM_CH(NUM_CH), .CH_W(CH_W), .PTR_W(PTR_W)) u_chain (
    .cur_ch    (cur_ch_q),
    .next_ptr  (next_ptr_i),
    .last_bits (last_bits_i),
    .chain_end (chain_end_w),
    .last_flag (last_flag_w),
    .next_ch   (next_ch_w)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_sel
    assign ch_sel_w[g] = (cur_ch_q == CH_W'(g));
  end

  assign act_w = dci_completion(linked_q, cnt_zero_i, done_ie_i[cur_ch_q],
                                chain_end_w, last_flag_w);
  assign done_set_w = run_done_w && act_w.set_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      cur_ch_q     <= '0;
      linked_q     <= 1'b0;
      xfer_start_o <= 1'b0;
      cause_clr_o  <= 1'b0;
      req_clr_o    <= '0;
      en_clr_o     <= '0;
    end else begin
      xfer_start_o <= 1'b0;
      cause_clr_o  <= 1'b0;
      req_clr_o    <= '0;
      en_clr_o     <= '0;
      unique case (state_q)
        ST_IDLE: begin
          if (invoke_w) begin
            state_q      <= ST_RUN;
            cur_ch_q     <= cause_ch_i;
            linked_q     <= link_mode_i;
            xfer_start_o <= 1'b1;
          end
        end
        ST_RUN: begin
          if (xfer_done_i) begin
            cause_clr_o <= act_w.cause_clr;
            req_clr_o   <= act_w.req_clr ? ch_sel_w : '0;
            en_clr_o    <= act_w.en_clr  ? ch_sel_w : '0;
            if (act_w.finish) begin
              state_q <= ST_SETTLE;
            end else begin
              cur_ch_q     <= next_ch_w;
              xfer_start_o <= 1'b1;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  dci_done_flag u_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (done_set_w),
    .clr_i  (done_flag_clr_i),
    .flag_o (done_flag_o)
  );

  assign busy_o    = (state_q == ST_RUN);
  assign xfer_ch_o = cur_ch_q;
endmodule

// File: rtl/dci_checker.sv
module dci_checker #(
  parameter int NUM_CH = 4,
  parameter int CH_W   = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy_o,
  input logic              xfer_start_o,
  input logic [CH_W-1:0]   xfer_ch_o,
  input logic              xfer_done_i,
  input logic              cnt_zero_i,
  input logic              cpu_irq_o,
  input logic              cause_clr_o,
  input logic [NUM_CH-1:0] req_clr_o,
  input logic              done_flag_o,
  input logic              done_flag_clr_i,
  input logic              invoke_w,
  input logic              run_done_w
);
  a_r3_no_irq_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !cpu_irq_o);

  a_r2_invoke_starts: assert property (@(posedge clk) disable iff (!rst_n)
    invoke_w |=> (busy_o && xfer_start_o));

  a_r12_channel_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !xfer_done_i) |=> (busy_o && $stable(xfer_ch_o)));

  a_r13_cause_clr_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cause_clr_o |=> !cause_clr_o);

  a_r4_req_clr_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_clr_o));

  a_r9_req_clr_keeps_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (req_clr_o != '0) |-> !cause_clr_o);

  a_r10_flag_held: assert property (@(posedge clk) disable iff (!rst_n)
    (done_flag_o && !done_flag_clr_i) |=> done_flag_o);

  a_r10_flag_rise_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_flag_o) |-> $past(run_done_w && cnt_zero_i));
endmodule

bind dma_cmpl_irq_ctrl dci_checker #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_dci_checker (
  .clk             (clk),
  .rst_n           (rst_n),
  .busy_o          (busy_o),
  .xfer_start_o    (xfer_start_o),
  .xfer_ch_o       (xfer_ch_o),
  .xfer_done_i     (xfer_done_i),
  .cnt_zero_i      (cnt_zero_i),
  .cpu_irq_o       (cpu_irq_o),
  .cause_clr_o     (cause_clr_o),
  .req_clr_o       (req_clr_o),
  .done_flag_o     (done_flag_o),
  .done_flag_clr_i (done_flag_clr_i),
  .invoke_w        (invoke_w),
  .run_done_w      (run_done_w)
);

// File: tb/dma_cmpl_irq_ctrl_test.sv
`timescale 1ns/1ps
module dma_cmpl_irq_ctrl_test;
  localparam int NCH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        cause_flag_i, cause_ie_i, link_mode_i, xfer_done_i, cnt_zero_i, done_flag_clr_i;
  logic [1:0]  cause_ch_i;
  logic [3:0]  req_bits_i, en_bits_i, done_ie_i, last_bits_i;
  logic [11:0] next_ptr_i;
  logic        busy_o, xfer_start_o, cause_clr_o, cpu_irq_o, done_flag_o;
  logic [1:0]  xfer_ch_o;
  logic [3:0]  req_clr_o, en_clr_o;

  dma_cmpl_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cause_flag_i(cause_flag_i), .cause_ie_i(cause_ie_i),
    .cause_ch_i(cause_ch_i), .req_bits_i(req_bits_i), .en_bits_i(en_bits_i),
    .done_ie_i(done_ie_i), .link_mode_i(link_mode_i), .next_ptr_i(next_ptr_i),
    .last_bits_i(last_bits_i), .xfer_done_i(xfer_done_i), .cnt_zero_i(cnt_zero_i),
    .done_flag_clr_i(done_flag_clr_i), .busy_o(busy_o), .xfer_start_o(xfer_start_o),
    .xfer_ch_o(xfer_ch_o), .cause_clr_o(cause_clr_o), .req_clr_o(req_clr_o),
    .en_clr_o(en_clr_o), .cpu_irq_o(cpu_irq_o), .done_flag_o(done_flag_o)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // Register-file model driven into the block.
  logic       m_cause, m_ie, m_link;
  logic [1:0] m_ch;
  logic [3:0] m_req, m_en, m_die, m_last;
  logic [2:0] m_ptr [NCH];
  logic       exp_flag = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive();
    cause_flag_i = m_cause; cause_ie_i = m_ie; cause_ch_i = m_ch;
    req_bits_i = m_req; en_bits_i = m_en; done_ie_i = m_die;
    link_mode_i = m_link; last_bits_i = m_last;
    next_ptr_i = {m_ptr[3], m_ptr[2], m_ptr[1], m_ptr[0]};
  endtask

  // Apply clear strobes visible in the current cycle to the model.
  task automatic absorb();
    if (cause_clr_o) m_cause = 1'b0;
    m_req = m_req & ~req_clr_o;
    m_en  = m_en  & ~en_clr_o;
    drive();
  endtask

  function automatic logic exp_irq();
    return m_cause && m_ie && !(m_req[m_ch] && m_en[m_ch]);
  endfunction

  // Expected {cause_clr, req_clr, en_clr} for an unlinked completion.
  function automatic logic [2:0] unlinked_outcome(input logic z, input logic ie);
    case ({z, ie})
      2'b11:   return 3'b010;   // keep cause, drop request
      2'b10:   return 3'b101;   // drop cause and enable
      default: return 3'b100;   // nonzero counter: drop cause only
    endcase
  endfunction

  // zmode: 0 random, 1 counter always zero, 2 counter never zero
  task automatic run_chain(input int zmode, input bit disturb);
    logic [1:0] cur;
    logic       linked;
    bit         fin;
    logic       z, is_end, set_done;
    logic [2:0] outc, ptr;
    cur = m_ch; linked = m_link; fin = 0;
    drive();
    @(negedge clk);
    chk("R2 busy after invoke", busy_o, 1);
    chk("R2 start pulse", xfer_start_o, 1);
    chk("R2 channel", xfer_ch_o, cur);
    chk("R3 irq held while DMA runs", cpu_irq_o, 0);
    if (disturb) begin
      cause_ch_i = m_ch + 2'd1; cause_ie_i = 1'b1; link_mode_i = ~m_link;
      for (int k = 0; k < 2; k++) begin
        @(negedge clk);
        chk("R12 still busy", busy_o, 1);
        chk("R12 channel held", xfer_ch_o, cur);
        chk("R12 no restart", xfer_start_o, 0);
        chk("R3 no irq when busy", cpu_irq_o, 0);
      end
      drive();
    end
    while (!fin) begin
      z = (zmode == 1) ? 1'b1 : (zmode == 2) ? 1'b0 : 1'($urandom % 2);
      xfer_done_i = 1'b1; cnt_zero_i = z;
      @(negedge clk);
      xfer_done_i = 1'b0; cnt_zero_i = 1'b0;
      ptr = m_ptr[cur];
      if (!linked) begin
        outc = unlinked_outcome(z, m_die[cur]);
        is_end = 1'b1; set_done = 1'b0;
        chk("R4/R5/R6 cause clear", cause_clr_o, outc[2]);
        chk("R4 request clear", req_clr_o, outc[1] ? (4'b1 << cur) : 4'b0);
        chk("R6 enable clear", en_clr_o, outc[0] ? (4'b1 << cur) : 4'b0);
      end else begin
        is_end = m_last[cur] || (ptr >= 3'd4);
        set_done = m_last[cur] && z && m_die[cur];
        chk("R8/R9 cause clear at chain end only", cause_clr_o, is_end);
        chk("R9 no request clear linked", req_clr_o, 0);
        chk("R8 enable clear on zero", en_clr_o, z ? (4'b1 << cur) : 4'b0);
      end
      if (set_done) exp_flag = 1'b1;
      chk(linked ? "R10/R11 done flag" : "R7 done flag untouched", done_flag_o, exp_flag);
      absorb();
      if (is_end) begin
        chk("R3 settle busy low", busy_o, 0);
        chk("R3 settle irq low", cpu_irq_o, 0);
        fin = 1;
      end else begin
        chk("R8 next start", xfer_start_o, 1);
        chk("R8 next channel", xfer_ch_o, ptr[1:0]);
        chk("R8 still busy", busy_o, 1);
        cur = ptr[1:0];
      end
    end
    @(negedge clk);
    chk("R3/R4 irq after completion", cpu_irq_o, exp_irq());
    chk("R13 cause strobe single cycle", cause_clr_o, 0);
    chk("R13 request strobe single cycle", req_clr_o, 0);
    chk("R13 enable strobe quiet", en_clr_o, 0);
    m_cause = 1'b0; drive();
    @(negedge clk);
    chk("R12 idle after run", busy_o, 0);
  endtask

  task automatic clear_flag();
    done_flag_clr_i = 1'b1;
    @(negedge clk);
    done_flag_clr_i = 1'b0;
    exp_flag = 1'b0;
    chk("R10 flag cleared by write", done_flag_o, 0);
  endtask

  task automatic base_cfg();
    m_cause = 1'b1; m_ie = 1'b1; m_ch = 2'd0; m_link = 1'b0;
    m_req = 4'hF; m_en = 4'hF; m_die = 4'hF; m_last = 4'hF;
    for (int i = 0; i < NCH; i++) m_ptr[i] = 3'd0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=hang expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed;
    logic [1:0] wc;
    seed = $urandom(32'd2024);
    m_cause = 0; m_ie = 0; m_ch = 0; m_link = 0;
    m_req = 0; m_en = 0; m_die = 0; m_last = 0;
    for (int i = 0; i < NCH; i++) m_ptr[i] = 3'd0;
    drive();
    xfer_done_i = 0; cnt_zero_i = 0; done_flag_clr_i = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy", busy_o, 0);
    chk("R1 start", xfer_start_o, 0);
    chk("R1 cause clr", cause_clr_o, 0);
    chk("R1 req clr", req_clr_o, 0);
    chk("R1 en clr", en_clr_o, 0);
    chk("R1 done flag", done_flag_o, 0);

    // R3: channel disabled, interrupt goes to the CPU, no DMA.
    base_cfg(); m_en = 4'b1110; drive();
    @(negedge clk);
    chk("R3 irq with channel disabled", cpu_irq_o, 1);
    @(negedge clk);
    chk("R3 no invocation", busy_o, 0);
    m_cause = 0; drive(); @(negedge clk);

    // Unlinked outcomes R4, R5, R6 on channel 2.
    base_cfg(); m_ch = 2'd2; run_chain(1, 0);               // R4
    base_cfg(); m_ch = 2'd2; run_chain(2, 0);               // R5
    base_cfg(); m_ch = 2'd2; m_die = 4'b1011; run_chain(1, 0); // R6

    // R10: chain 0 -> 2 -> 1 (last), all counters zero.
    base_cfg(); m_link = 1; m_last = 4'b0010;
    m_ptr[0] = 3'd2; m_ptr[2] = 3'd1; m_ptr[1] = 3'd0;
    run_chain(1, 1);
    chk("R10 flag set at chain end", done_flag_o, 1);
    @(negedge clk);
    chk("R10 flag held", done_flag_o, 1);
    clear_flag();

    // R11: invalid pointer ends chain without done flag.
    base_cfg(); m_link = 1; m_ch = 2'd3; m_last = 4'b0000; m_ptr[3] = 3'd5;
    run_chain(1, 0);
    chk("R11 no flag on pointer end", done_flag_o, 0);

    // Random mix.
    for (int n = 0; n < 60; n++) begin
      m_cause = 1; m_ie = 1'($urandom % 2); m_ch = 2'($urandom % 4);
      m_req = 4'($urandom) | (4'b1 << m_ch); m_en = 4'($urandom) | (4'b1 << m_ch);
      m_die = 4'($urandom); m_link = 1'($urandom % 2); m_last = 4'($urandom);
      for (int i = 0; i < NCH; i++) m_ptr[i] = 3'($urandom % 8);
      wc = m_ch;
      for (int k = 0; k < 4; k++) begin
        if (m_last[wc] || m_ptr[wc] >= 3'd4) break;
        if (k == 3) begin m_last[wc] = 1'b1; break; end
        wc = m_ptr[wc][1:0];
      end
      run_chain(0, ($urandom % 3) == 0);
      if (($urandom % 2) == 0) clear_flag();
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule